// File: doc/BRIEF.md
# Branch and Jump Resolver

The resolver takes one decoded control-flow operation and settles it within a single cycle of combinational logic. From the operation code, the address of the current instruction, the two source register values, the 16-bit branch displacement and the 26-bit jump field, it decides whether control leaves the sequential path. It also produces the destination address and the return address. For the linking forms, it names the register that receives the return address.

A decode or execute stage drives the inputs and consumes the results in the same cycle. The resolver holds no state. The block covers:

- equality compares between two registers;
- four signed tests of a single register against zero;
- jumps to a region-relative immediate address, with or without linking;
- jumps to a register value, with or without linking.

Fetch redirection, delay-slot sequencing and exception handling belong to the surrounding pipeline.

Top module: `flow_resolver`

## Requirements
- R1: Code 1 (equal-branch) sets `take_flow` exactly when `rs_val` equals `rt_val`, and code 2 (unequal-branch) sets it exactly when they differ.
- R2: Codes 3, 4, 5 and 6 treat `rs_val` as a two's-complement number and set `take_flow` when it is >= 0, > 0, <= 0 and < 0 respectively.
- R3: For codes 1 to 6, `flow_target` is `cur_pc + 4` plus the sign-extended `br_off` times four, modulo 2^32, whether or not the branch is taken.
- R4: For codes 7 (region jump) and 8 (region jump with link), `flow_target` is bits 31..28 of `cur_pc + 4`, then `jmp_field`, then two zero bits.
- R5: For codes 9 (register jump) and 10 (register jump with link), `flow_target` equals `rs_val`.
- R6: Code 8 sets `link_wr` with `link_sel` = 31, and code 10 sets `link_wr` with `link_sel` = `rd_sel`. Every other code clears `link_wr` and drives `link_sel` to 0.
- R7: `link_data` always equals `cur_pc + 8` modulo 2^32, which is the address after the delay slot.
- R8: Code 0 and codes 11 to 15 are not control flow: `take_flow` and `link_wr` are 0 and `flow_target` is `cur_pc + 4`, whatever the register values are.
- R9: Codes 7 to 10 always set `take_flow`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Control-flow operation code (see requirements) |
| cur_pc | input | 32 | Address of the control-flow instruction |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| br_off | input | 16 | Branch displacement in words, signed |
| jmp_field | input | 26 | Word index within the current 256 MiB region |
| rd_sel | input | 5 | Destination register for register jump with link |
| take_flow | output | 1 | Control leaves the sequential path |
| flow_target | output | 32 | Destination address |
| link_wr | output | 1 | Write the return address to a register |
| link_sel | output | 5 | Register that receives the return address |
| link_data | output | 32 | Return address |

## Verification
The bench targets the sign boundary of the zero tests: rs = 0, 1, -1, 0x7FFFFFFF and 0x80000000. An unsigned compare or a missing zero case flips `take_flow` at one of these values. It drives the most negative displacement, a displacement of -1, and a branch whose target wraps past 2^32. A zero-extended displacement or one added to `cur_pc` rather than `cur_pc + 4` lands the target far away or four bytes short. A region jump is issued from the last word of a region, so the upper bits must come from `cur_pc + 4`; an implementation that takes them from `cur_pc` targets the wrong 256 MiB region. Non-control codes with equal registers and register jumps with `rd_sel` = 0 check that no stray taken or link write appears.

// File: rtl/flow_pkg.sv
`timescale 1ns/1ps
// flow_pkg: shared widths and the operation code set of the resolver.
// Assumes 4-bit codes; codes not listed are treated as non-control.
package flow_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        FOP_NONE  = 4'd0,
        FOP_EQ    = 4'd1,
        FOP_NE    = 4'd2,
        FOP_GEZ   = 4'd3,
        FOP_GTZ   = 4'd4,
        FOP_LEZ   = 4'd5,
        FOP_LTZ   = 4'd6,
        FOP_JREG  = 4'd7,
        FOP_JREGL = 4'd8,
        FOP_JR    = 4'd9,
        FOP_JRL   = 4'd10
    } flow_op_e;

    // True for every code that transfers control unconditionally.
    function automatic logic is_jump(input logic [OP_W-1:0] op);
        return (op == FOP_JREG) || (op == FOP_JREGL) ||
               (op == FOP_JR)   || (op == FOP_JRL);
    endfunction

    // True for the conditional branch codes.
    function automatic logic is_branch(input logic [OP_W-1:0] op);
        return (op >= FOP_EQ) && (op <= FOP_LTZ);
    endfunction
endpackage

// File: rtl/flow_cond.sv
`timescale 1ns/1ps
// flow_cond: decides whether the operation leaves the sequential path.
// Assumes rs/rt are two's-complement for the zero tests; jumps are
// always taken and unknown codes are never taken.
module flow_cond
    import flow_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [XLEN-1:0] rs,
    input  logic [XLEN-1:0] rt,
    output logic            taken
);
    localparam int SIGN_BIT = XLEN - 1;

    logic same;
    logic neg;
    logic zero;

    // Shared compare terms used by all conditional codes.
    always_comb begin
        same = (rs == rt);
        neg  = rs[SIGN_BIT];
        zero = ~|rs;
    end

    // Select the outcome for the current operation.
    always_comb begin
        unique case (op)
            FOP_EQ:  taken = same;
            FOP_NE:  taken = ~same;
            FOP_GEZ: taken = ~neg;
            FOP_GTZ: taken = ~neg & ~zero;
            FOP_LEZ: taken = neg | zero;
            FOP_LTZ: taken = neg;
            FOP_JREG, FOP_JREGL, FOP_JR, FOP_JRL: taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/flow_dest.sv
`timescale 1ns/1ps
// flow_dest: computes the destination and the return address.
// Assumes a delay slot follows every control instruction, so the base
// for relative and region addressing is pc + one instruction.
module flow_dest
    import flow_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [OP_W-1:0]  op,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rs,
    input  logic [OFF_W-1:0] off,
    input  logic [IDX_W-1:0] idx,
    output logic [XLEN-1:0]  dest,
    output logic [XLEN-1:0]  ret
);
    localparam int          SH       = 2;
    localparam int          EXT_W    = XLEN - OFF_W;
    localparam int          REGION_W = XLEN - IDX_W - SH;
    localparam logic [XLEN-1:0] WORD = XLEN'(1 << SH);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] rel_dest;
    logic [XLEN-1:0] region_dest;

    // Candidate addresses for each addressing form.
    always_comb begin
        seq_pc      = pc + WORD;
        off_ext     = {{EXT_W{off[OFF_W-1]}}, off};
        rel_dest    = seq_pc + (off_ext << SH);
        region_dest = {seq_pc[XLEN-1 -: REGION_W], idx, {SH{1'b0}}};
        ret         = seq_pc + WORD;
    end

    // Pick the addressing form for the operation.
    always_comb begin
        if (is_branch(op))
            dest = rel_dest;
        else if (op == FOP_JREG || op == FOP_JREGL)
            dest = region_dest;
        else if (op == FOP_JR || op == FOP_JRL)
            dest = rs;
        else
            dest = seq_pc;
    end
endmodule

// File: rtl/flow_link.sv
`timescale 1ns/1ps
// flow_link: chooses whether and where the return address is written.
// Assumes LINK_REG is the fixed return register of region jump with link.
module flow_link
    import flow_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  logic [OP_W-1:0]  op,
    input  logic [REG_W-1:0] rd,
    output logic             we,
    output logic [REG_W-1:0] sel
);
    // Map linking codes to a write enable and a register index.
    always_comb begin
        we  = 1'b0;
        sel = '0;
        if (op == FOP_JREGL) begin
            we  = 1'b1;
            sel = REG_W'(LINK_REG);
        end else if (op == FOP_JRL) begin
            we  = 1'b1;
            sel = rd;
        end
    end
endmodule

// File: rtl/flow_resolver.sv
`timescale 1ns/1ps
// flow_resolver: single-cycle branch and jump resolution.
// Purely combinational; the caller registers the results as needed.
module flow_resolver
    import flow_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFF_W    = 16,
    parameter int IDX_W    = 26,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  logic [OP_W-1:0]  op_code,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [OFF_W-1:0] br_off,
    input  logic [IDX_W-1:0] jmp_field,
    input  logic [REG_W-1:0] rd_sel,
    output logic             take_flow,
    output logic [XLEN-1:0]  flow_target,
    output logic             link_wr,
    output logic [REG_W-1:0] link_sel,
    output logic [XLEN-1:0]  link_data
);
    flow_cond #(.XLEN(XLEN)) u_cond (
        .op    (op_code),
        .rs    (rs_val),
        .rt    (rt_val),
        .taken (take_flow)
    );

    flow_dest #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dest (
        .op   (op_code),
        .pc   (cur_pc),
        .rs   (rs_val),
        .off  (br_off),
        .idx  (jmp_field),
        .dest (flow_target),
        .ret  (link_data)
    );

    flow_link #(.REG_W(REG_W), .LINK_REG(LINK_REG)) u_link (
        .op  (op_code),
        .rd  (rd_sel),
        .we  (link_wr),
        .sel (link_sel)
    );
endmodule

// File: rtl/flow_resolver_check.sv
`timescale 1ns/1ps
// flow_resolver_check: cross-unit consistency checks on the resolver.
// Combinational block, so the checks are immediate and re-evaluate on change.
module flow_resolver_check
    import flow_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input logic [OP_W-1:0]  op_code,
    input logic [XLEN-1:0]  rs_val,
    input logic [REG_W-1:0] rd_sel,
    input logic             take_flow,
    input logic [XLEN-1:0]  flow_target,
    input logic             link_wr,
    input logic [REG_W-1:0] link_sel
);
    // Check taken/link/target relations after each settle.
    always_comb begin
        if (!is_jump(op_code) && !is_branch(op_code)) begin
            a_r8_idle_quiet: assert (!take_flow && !link_wr)
                else $error("R8 non-control code raised taken or link");
        end
        if (link_wr) begin
            a_r6_link_src: assert (op_code == FOP_JREGL || op_code == FOP_JRL)
                else $error("R6 link write on non-linking code");
        end
        if (op_code == FOP_JREGL) begin
            a_r6_fixed_reg: assert (link_wr && link_sel == REG_W'(LINK_REG))
                else $error("R6 region link not to fixed register");
        end
        if (op_code == FOP_JRL) begin
            a_r6_rd_reg: assert (link_wr && link_sel == rd_sel)
                else $error("R6 register link not to rd");
        end
        if (is_jump(op_code)) begin
            a_r9_jump_taken: assert (take_flow)
                else $error("R9 jump not taken");
        end
        if (op_code == FOP_JR || op_code == FOP_JRL) begin
            a_r5_reg_target: assert (flow_target == rs_val)
                else $error("R5 register jump target mismatch");
        end
    end
endmodule

bind flow_resolver flow_resolver_check #(
    .XLEN(XLEN), .REG_W(REG_W), .LINK_REG(LINK_REG)
) u_flow_check (
    .op_code     (op_code),
    .rs_val      (rs_val),
    .rd_sel      (rd_sel),
    .take_flow   (take_flow),
    .flow_target (flow_target),
    .link_wr     (link_wr),
    .link_sel    (link_sel)
);

// File: tb/flow_resolver_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expectations, monitor compares at negedge.
module flow_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] cur_pc = '0, rs_val = '0, rt_val = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic [4:0]  rd_sel = '0;
    logic        take_flow, link_wr;
    logic [31:0] flow_target, link_data;
    logic [4:0]  link_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic        tk;
        logic [31:0] dst;
        logic        we;
        logic [4:0]  sel;
        logic [31:0] lnk;
        string       req;
    } exp_t;

    exp_t sb[$];
    exp_t got;

    always #4 clk = ~clk;

    flow_resolver uut (
        .op_code(op_code), .cur_pc(cur_pc), .rs_val(rs_val), .rt_val(rt_val),
        .br_off(br_off), .jmp_field(jmp_field), .rd_sel(rd_sel),
        .take_flow(take_flow), .flow_target(flow_target), .link_wr(link_wr),
        .link_sel(link_sel), .link_data(link_data)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [3:0] op, input logic [31:0] pc,
                                   input logic [31:0] rs, input logic [31:0] rt,
                                   input logic [15:0] off, input logic [25:0] jf,
                                   input logic [4:0] rd, input string req);
        exp_t e;
        int signed srs;
        logic [31:0] nxt, rel;
        srs  = $signed(rs);
        nxt  = pc + 32'd4;
        rel  = nxt + 32'($signed(off) * 4);
        e.tk = 1'b0; e.we = 1'b0; e.sel = 5'd0; e.dst = nxt;
        e.lnk = pc + 32'd8; e.req = req;
        case (op)
            4'd1: begin e.tk = (rs == rt); e.dst = rel; end
            4'd2: begin e.tk = (rs != rt); e.dst = rel; end
            4'd3: begin e.tk = (srs >= 0); e.dst = rel; end
            4'd4: begin e.tk = (srs > 0);  e.dst = rel; end
            4'd5: begin e.tk = (srs <= 0); e.dst = rel; end
            4'd6: begin e.tk = (srs < 0);  e.dst = rel; end
            4'd7: begin e.tk = 1'b1; e.dst = {nxt[31:28], jf, 2'b00}; end
            4'd8: begin e.tk = 1'b1; e.dst = {nxt[31:28], jf, 2'b00};
                        e.we = 1'b1; e.sel = 5'd31; end
            4'd9: begin e.tk = 1'b1; e.dst = rs; end
            4'd10: begin e.tk = 1'b1; e.dst = rs; e.we = 1'b1; e.sel = rd; end
            default: ;
        endcase
        return e;
    endfunction

    // Driver: apply one stimulus per cycle and queue its expectation.
    task automatic send(input logic [3:0] op, input logic [31:0] pc,
                        input logic [31:0] rs, input logic [31:0] rt,
                        input logic [15:0] off, input logic [25:0] jf,
                        input logic [4:0] rd, input string req);
        @(posedge clk);
        #1;
        op_code = op; cur_pc = pc; rs_val = rs; rt_val = rt;
        br_off = off; jmp_field = jf; rd_sel = rd;
        sb.push_back(model(op, pc, rs, rt, off, jf, rd, req));
    endtask

    // Monitor: compare the settled outputs mid-cycle.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            got = sb.pop_front();
            checks++;
            if (take_flow !== got.tk || flow_target !== got.dst ||
                link_wr !== got.we || link_sel !== got.sel ||
                link_data !== got.lnk) begin
                errors++;
                $display("FAIL %s got tk=%b dst=%h we=%b sel=%0d lnk=%h exp tk=%b dst=%h we=%b sel=%0d lnk=%h",
                         got.req, take_flow, flow_target, link_wr, link_sel,
                         link_data, got.tk, got.dst, got.we, got.sel, got.lnk);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8: initial idle state with all-zero inputs
        send(4'd0, 32'h0, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0, "R8 idle");
        // R1: equality branches
        send(4'd1, 32'h100, 32'h5, 32'h5, 16'h3, 26'h0, 5'd0, "R1 eq taken");
        send(4'd1, 32'h100, 32'h5, 32'h6, 16'h3, 26'h0, 5'd0, "R1 eq not taken");
        send(4'd2, 32'h200, 32'h1, 32'h80000001, 16'h10, 26'h0, 5'd0, "R1 ne taken");
        send(4'd2, 32'h200, 32'hdead, 32'hdead, 16'h10, 26'h0, 5'd0, "R1 ne not taken");
        // R2: signed zero tests at every sign boundary
        for (int op = 3; op <= 6; op++) begin
            send(4'(op), 32'h1000, 32'h0, 32'h0, 16'h2, 26'h0, 5'd0, "R2 zero");
            send(4'(op), 32'h1000, 32'h1, 32'h0, 16'h2, 26'h0, 5'd0, "R2 plus one");
            send(4'(op), 32'h1000, 32'hffffffff, 32'h0, 16'h2, 26'h0, 5'd0, "R2 minus one");
            send(4'(op), 32'h1000, 32'h7fffffff, 32'h0, 16'h2, 26'h0, 5'd0, "R2 max pos");
            send(4'(op), 32'h1000, 32'h80000000, 32'h0, 16'h2, 26'h0, 5'd0, "R2 min neg");
        end
        // R3: displacement corner cases
        send(4'd1, 32'h100, 32'h0, 32'h0, 16'hffff, 26'h0, 5'd0, "R3 minus one word");
        send(4'd1, 32'h40000, 32'h0, 32'h0, 16'h8000, 26'h0, 5'd0, "R3 most negative");
        send(4'd1, 32'h40000, 32'h0, 32'h0, 16'h7fff, 26'h0, 5'd0, "R3 most positive");
        send(4'd2, 32'hfffffff8, 32'h0, 32'h1, 16'h1, 26'h0, 5'd0, "R3 wrap");
        send(4'd1, 32'h300, 32'h1, 32'h2, 16'h40, 26'h0, 5'd0, "R3 target when not taken");
        // R4 R9: region jumps, including the last word of a region
        send(4'd7, 32'h0ffffffc, 32'h0, 32'h0, 16'h0, 26'h3ffffff, 5'd0, "R4 region crossing");
        send(4'd7, 32'h80001000, 32'h0, 32'h0, 16'h0, 26'h0000123, 5'd0, "R4 R9 region jump");
        // R6 R7: region jump with link
        send(4'd8, 32'h00400000, 32'h0, 32'h0, 16'h0, 26'h0100010, 5'd7, "R6 R7 region link");
        send(4'd8, 32'hfffffffc, 32'h0, 32'h0, 16'h0, 26'h0000001, 5'd7, "R7 link wrap");
        // R5: register jumps
        send(4'd9, 32'h500, 32'h12345678, 32'h0, 16'h0, 26'h0, 5'd9, "R5 register jump");
        send(4'd10, 32'h600, 32'h00abcdef, 32'h0, 16'h0, 26'h0, 5'd5, "R5 R6 register link");
        send(4'd10, 32'h700, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0, "R6 link rd zero");
        // R8: non-control codes ignore equal registers and fields
        for (int op = 11; op <= 15; op++)
            send(4'(op), 32'h900, 32'h7, 32'h7, 16'hffff, 26'h3ffffff, 5'd31, "R8 non-control");
        send(4'd0, 32'hfffffffc, 32'h0, 32'h0, 16'h1, 26'h1, 5'd3, "R8 idle wrap");
        wait (sb.size() == 0);
        @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule